// File: doc/BRIEF.md
# Stage Counter and Relative Branch Resolver

This block sits beside the decode stage of a small sequencer core. Each cycle the core may hand it one control operation: a relative branch conditioned on R0, a relative branch conditioned on a private 8-bit loop counter, a loop-counter clear, or a loop-counter add. With each operation come the word-addressed current PC, the R0 value, a threshold, a two-bit comparison code, a signed byte offset and an increment amount. One clock later the block presents a completion pulse, a taken flag and the next PC in words. The loop counter is visible on an output and can be changed only by the two counter operations.

Branch offsets arrive in bytes while the PC counts 32-bit words, so the offset is shifted right arithmetically by two before it is added to the PC. Comparisons are unsigned: 16 bits wide for R0, and 8 bits wide for the counter, using only the low byte of the threshold.

A three-state controller records what was accepted. `S_IDLE` is entered from any state when no valid operation is presented. `S_BRANCH` is entered from any state when either branch form is presented and shows the registered branch result for one cycle. `S_STAGE` is entered from any state when a clear or add is presented and shows the completion pulse with the sequential next PC. Back-to-back operations move directly between `S_BRANCH` and `S_STAGE` with no return to `S_IDLE`.

Top module: `branch_stage_unit`

## Requirements
- R1: After reset, `done` and `taken` are 0, `stage_cnt` is 0 and `next_pc` is 0.
- R2: Operation code 3 (counter clear) makes `stage_cnt` 0 on the cycle after it is presented.
- R3: Operation code 4 (counter add) makes `stage_cnt` equal to its previous value plus `inc_amt`, modulo 256, on the following cycle.
- R4: Operation code 1 (R0 branch) is taken when `r0_val` compared unsigned against the full 16-bit `thresh` satisfies `cond`: 0 = equal, 1 = less-than, 2 = greater-or-equal.
- R5: Operation code 2 (counter branch) is taken when `stage_cnt` compared unsigned against `thresh[7:0]` satisfies `cond` with the same encoding; `thresh[15:8]` has no effect.
- R6: On a taken branch, `next_pc` equals `cur_pc` plus the signed `byte_ofs` shifted right arithmetically by 2, modulo 2^11.
- R7: On a branch not taken, and after any counter operation, `next_pc` equals `cur_pc` + 1 modulo 2^11.
- R8: Comparison code 3 never takes a branch.
- R9: `done` is 1 exactly on the cycle after a valid operation (codes 1 to 4). Codes 0 and 5 to 7 yield `done` = 0, `taken` = 0, leave `next_pc` at its last value, and leave `stage_cnt` unchanged. Branches never change `stage_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 3 | 0 none, 1 R0 branch, 2 counter branch, 3 counter clear, 4 counter add |
| cur_pc | input | 11 | Word address of the current instruction |
| r0_val | input | 16 | Value of R0 |
| thresh | input | 16 | Branch threshold (counter branch uses bits 7:0) |
| cond | input | 2 | 0 equal, 1 less-than, 2 greater-or-equal, 3 never |
| byte_ofs | input | 8 | Signed branch offset in bytes |
| inc_amt | input | 8 | Amount added by a counter add |
| done | output | 1 | Operation completed last cycle |
| taken | output | 1 | Branch taken |
| next_pc | output | 11 | Resolved next PC in words |
| stage_cnt | output | 8 | Loop counter |

## Verification
Every result is due exactly one clock after its operation: `done`, `taken` and `next_pc` are registered at the edge that accepts the operation, and `stage_cnt` updates on that same edge. The bench drives each operation on a falling edge, lets one rising edge pass, and samples all outputs on the next falling edge, so every check reads the value from the edge that consumed the stimulus. Counter branches are modelled against the bench's own copy of the counter as it stood before that edge.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_BR_R0     = 3'd1,
        OP_BR_STAGE  = 3'd2,
        OP_STAGE_RST = 3'd3,
        OP_STAGE_INC = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CMP_EQ    = 2'd0,
        CMP_LT    = 2'd1,
        CMP_GE    = 2'd2,
        CMP_NEVER = 2'd3
    } cmp_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_BRANCH = 2'd1,
        S_STAGE  = 2'd2
    } state_e;

endpackage

// File: rtl/bsu_compare.sv
module bsu_compare
    import bsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [1:0]   cond,
    output logic         hit
);

    always_comb begin
        unique case (cmp_e'(cond))
            CMP_EQ:    hit = (lhs == rhs);
            CMP_LT:    hit = (lhs <  rhs);
            CMP_GE:    hit = (lhs >= rhs);
            CMP_NEVER: hit = 1'b0;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bsu_stage_counter.sv
module bsu_stage_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] add_amt,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (add_en) begin
            cnt <= cnt + add_amt;
        end
    end

endmodule

// File: rtl/bsu_target.sv
module bsu_target #(
    parameter int PC_W  = 11,
    parameter int OFS_W = 8,
    parameter int SHIFT = 2
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFS_W-1:0] ofs,
    input  logic             take,
    output logic [PC_W-1:0]  dest
);

    logic signed [OFS_W-1:0] word_ofs;
    logic        [PC_W-1:0]  word_ofs_ext;

    assign word_ofs = $signed(ofs) >>> SHIFT;

    generate
        if (PC_W > OFS_W) begin : g_extend
            assign word_ofs_ext = {{(PC_W-OFS_W){word_ofs[OFS_W-1]}}, word_ofs};
        end else begin : g_trunc
            assign word_ofs_ext = word_ofs[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        if (take) begin
            dest = pc + word_ofs_ext;
        end else begin
            dest = pc + PC_W'(1);
        end
    end

endmodule

// File: rtl/branch_stage_unit.sv
module branch_stage_unit
    import bsu_pkg::*;
#(
    parameter int PC_W      = 11,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int OFS_W     = 8,
    parameter int OFS_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_kind,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [DATA_W-1:0] r0_val,
    input  logic [DATA_W-1:0] thresh,
    input  logic [1:0]        cond,
    input  logic [OFS_W-1:0]  byte_ofs,
    input  logic [CNT_W-1:0]  inc_amt,
    output logic              done,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc,
    output logic [CNT_W-1:0]  stage_cnt
);

    localparam int TH_LO_W = (CNT_W < DATA_W) ? CNT_W : DATA_W;

    logic is_br_r0, is_br_stage, is_clr, is_add;
    logic hit_r0, hit_stage, br_hit;
    logic [PC_W-1:0]  resolved_pc;
    logic [CNT_W-1:0] stage_thresh;

    state_e          state_q, state_d;
    logic            taken_q;
    logic [PC_W-1:0] pc_q;

    // operation decode
    always_comb begin
        is_br_r0    = 1'b0;
        is_br_stage = 1'b0;
        is_clr      = 1'b0;
        is_add      = 1'b0;
        case (op_kind)
            OP_BR_R0:     is_br_r0    = 1'b1;
            OP_BR_STAGE:  is_br_stage = 1'b1;
            OP_STAGE_RST: is_clr      = 1'b1;
            OP_STAGE_INC: is_add      = 1'b1;
            default:      ;
        endcase
    end

    assign stage_thresh = CNT_W'(thresh[TH_LO_W-1:0]);

    bsu_compare #(.W(DATA_W)) u_cmp_r0 (
        .lhs  (r0_val),
        .rhs  (thresh),
        .cond (cond),
        .hit  (hit_r0)
    );

    bsu_compare #(.W(CNT_W)) u_cmp_stage (
        .lhs  (stage_cnt),
        .rhs  (stage_thresh),
        .cond (cond),
        .hit  (hit_stage)
    );

    assign br_hit = (is_br_r0 & hit_r0) | (is_br_stage & hit_stage);

    bsu_target #(.PC_W(PC_W), .OFS_W(OFS_W), .SHIFT(OFS_SHIFT)) u_target (
        .pc   (cur_pc),
        .ofs  (byte_ofs),
        .take (br_hit),
        .dest (resolved_pc)
    );

    bsu_stage_counter #(.W(CNT_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (is_clr),
        .add_en  (is_add),
        .add_amt (inc_amt),
        .cnt     (stage_cnt)
    );

    // next-state selection: every state follows the presented operation
    always_comb begin
        if (is_br_r0 || is_br_stage) begin
            state_d = S_BRANCH;
        end else if (is_clr || is_add) begin
            state_d = S_STAGE;
        end else begin
            state_d = S_IDLE;
        end
    end

    // state register with captured branch result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            taken_q <= 1'b0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            taken_q <= br_hit;
            if (state_d != S_IDLE) begin
                pc_q <= resolved_pc;
            end
        end
    end

    // output decode
    always_comb begin
        next_pc = pc_q;
        unique case (state_q)
            S_IDLE: begin
                done  = 1'b0;
                taken = 1'b0;
            end
            S_BRANCH: begin
                done  = 1'b1;
                taken = taken_q;
            end
            S_STAGE: begin
                done  = 1'b1;
                taken = 1'b0;
            end
            default: begin
                done  = 1'b0;
                taken = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
    parameter int PC_W   = 11,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int OFS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_kind,
    input logic [PC_W-1:0]   cur_pc,
    input logic [DATA_W-1:0] r0_val,
    input logic [DATA_W-1:0] thresh,
    input logic [1:0]        cond,
    input logic [OFS_W-1:0]  byte_ofs,
    input logic [CNT_W-1:0]  inc_amt,
    input logic              done,
    input logic              taken,
    input logic [PC_W-1:0]   next_pc,
    input logic [CNT_W-1:0]  stage_cnt
);

    logic is_br, is_valid, ofs_seen;
    assign is_br    = (op_kind == 3'd1) || (op_kind == 3'd2);
    assign is_valid = (op_kind >= 3'd1) && (op_kind <= 3'd4);
    assign ofs_seen = ^byte_ofs;

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 3'd3) |=> (stage_cnt == '0));

    p_add_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 3'd4) |=> (stage_cnt == CNT_W'($past(stage_cnt) + $past(inc_amt))));

    p_r0_ge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 3'd1 && cond == 2'd2 && r0_val >= thresh) |=> taken);

    p_stage_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 3'd2 && cond == 2'd0 && thresh[CNT_W-1:0] == stage_cnt) |=> taken);

    p_seq_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_valid && (ofs_seen || !ofs_seen)) |=> (taken || next_pc == PC_W'($past(cur_pc) + 1)));

    p_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_br && cond == 2'd3) |=> !taken);

    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_valid |=> (!done && !taken && $stable(next_pc) && $stable(stage_cnt)));

    p_br_keeps_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_br |=> (done && $stable(stage_cnt)));

    p_taken_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> done);

endmodule

bind branch_stage_unit bsu_checker #(
    .PC_W(PC_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .OFS_W(OFS_W)
) u_bsu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_kind   (op_kind),
    .cur_pc    (cur_pc),
    .r0_val    (r0_val),
    .thresh    (thresh),
    .cond      (cond),
    .byte_ofs  (byte_ofs),
    .inc_amt   (inc_amt),
    .done      (done),
    .taken     (taken),
    .next_pc   (next_pc),
    .stage_cnt (stage_cnt)
);

// File: tb/tb_branch_stage_unit.sv
`timescale 1ns/1ps
module tb_branch_stage_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_kind;
    logic [10:0] cur_pc;
    logic [15:0] r0_val;
    logic [15:0] thresh;
    logic [1:0]  cond;
    logic [7:0]  byte_ofs;
    logic [7:0]  inc_amt;
    logic        done;
    logic        taken;
    logic [10:0] next_pc;
    logic [7:0]  stage_cnt;

    int checks = 0;
    int errors = 0;
    int exp_stage = 0;
    int exp_pc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    branch_stage_unit dut (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .cur_pc(cur_pc),
        .r0_val(r0_val), .thresh(thresh), .cond(cond), .byte_ofs(byte_ofs),
        .inc_amt(inc_amt), .done(done), .taken(taken), .next_pc(next_pc),
        .stage_cnt(stage_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit cmp_ok(input int a, input int b, input int cd);
        case (cd)
            0: return a == b;
            1: return a < b;
            2: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    // called on a falling edge; returns on the next falling edge after checks
    task automatic run_op(input int k, input int pc, input int r0, input int th,
                          input int cd, input int ofs, input int inc, input string req);
        bit exp_taken, exp_done;
        int ofs_s;
        exp_done  = (k >= 1 && k <= 4);
        exp_taken = 1'b0;
        if (k == 1) exp_taken = cmp_ok(r0 & 16'hFFFF, th & 16'hFFFF, cd);
        if (k == 2) exp_taken = cmp_ok(exp_stage, th & 8'hFF, cd);
        ofs_s = (ofs & 8'hFF);
        if (ofs_s > 127) ofs_s = ofs_s - 256;
        if (exp_done) begin
            if (exp_taken) exp_pc = (pc + (ofs_s >>> 2)) & 11'h7FF;
            else           exp_pc = (pc + 1) & 11'h7FF;
        end
        if (k == 3) exp_stage = 0;
        if (k == 4) exp_stage = (exp_stage + inc) & 8'hFF;
        op_kind  = 3'(k);
        cur_pc   = 11'(pc);
        r0_val   = 16'(r0);
        thresh   = 16'(th);
        cond     = 2'(cd);
        byte_ofs = 8'(ofs);
        inc_amt  = 8'(inc);
        @(posedge clk);
        @(negedge clk);
        chk({req, " done"},  int'(done),      int'(exp_done));
        chk({req, " taken"}, int'(taken),     int'(exp_taken));
        chk({req, " pc"},    int'(next_pc),   exp_pc);
        chk({req, " cnt"},   int'(stage_cnt), exp_stage);
    endtask

    initial begin
        rst_n = 1'b0; op_kind = '0; cur_pc = '0; r0_val = '0; thresh = '0;
        cond = '0; byte_ofs = '0; inc_amt = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done",  int'(done), 0);
        chk("R1 taken", int'(taken), 0);
        chk("R1 pc",    int'(next_pc), 0);
        chk("R1 cnt",   int'(stage_cnt), 0);
        rst_n = 1'b1;

        // R4, R8: R0 branch, sweep of values, thresholds and codes
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int cd = 0; cd < 4; cd++)
                    run_op(1, (a * 97 + b) & 11'h7FF, (a * 4099) & 16'hFFFF,
                           (b * 4099) & 16'hFFFF, cd, (a * 16 + b) & 8'hFF, 0,
                           cd == 3 ? "R8" : "R4");
        // R4 boundary values
        run_op(1, 5, 16'hFFFF, 16'hFFFF, 0, 8, 0, "R4");
        run_op(1, 5, 16'hFFFE, 16'hFFFF, 1, 8, 0, "R4");
        run_op(1, 5, 16'hFFFF, 16'h0000, 2, 8, 0, "R4");
        run_op(1, 5, 16'h0000, 16'h0000, 1, 8, 0, "R4");

        // R6: every byte offset, taken, around the PC wrap points
        for (int o = 0; o < 256; o++) begin
            run_op(1, 3, 7, 7, 0, o, 0, "R6");
            run_op(1, 11'h7FE, 7, 7, 0, o, 0, "R6");
        end

        // R7: not-taken sequential, including PC wrap
        run_op(1, 11'h7FF, 1, 2, 0, 40, 0, "R7");
        run_op(1, 100, 1, 2, 2, 40, 0, "R7");

        // R2, R3, R5: counter operations and counter branches
        run_op(3, 10, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 300; i++) begin
            run_op(4, i & 11'h7FF, 0, 0, 0, 0, (i * 37 + 5) & 8'hFF, "R3");
            for (int cd = 0; cd < 4; cd++)
                run_op(2, (i * 3) & 11'h7FF, 16'h1234, ((i * 53) & 8'hFF) | 16'hAB00,
                       cd, (i * 11) & 8'hFF, 0, cd == 3 ? "R8" : "R5");
            run_op(2, 50, 0, exp_stage | 16'h5500, 0, -16, 0, "R5");
            if (i % 50 == 49) run_op(3, 20, 0, 0, 0, 0, 0, "R2");
        end
        // R3 wrap exactly
        run_op(3, 0, 0, 0, 0, 0, 0, "R2");
        run_op(4, 0, 0, 0, 0, 0, 255, "R3");
        run_op(4, 0, 0, 0, 0, 0, 1, "R3");
        run_op(2, 9, 0, 16'hFF00, 0, 4, 0, "R5");

        // R9: idle and undefined codes leave everything alone
        run_op(4, 0, 0, 0, 0, 0, 77, "R3");
        for (int k = 5; k < 8; k++) run_op(k, 33, 1, 1, 0, 12, 9, "R9");
        run_op(0, 44, 1, 1, 0, 12, 9, "R9");
        run_op(0, 44, 1, 1, 0, 12, 9, "R9");

        op_kind = '0;
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule